// File: doc/BRIEF.md
# SPI Slave Register Bank

This block lets an external SPI master read and write a bank of 16-bit registers over a four-wire serial link. The link runs in mode 0. MOSI is captured on the rising SCK edge, and MISO moves on the falling edge. Every word on the wire is a 16-bit frame, most significant bit first. The master may hold slave select low for as many frames as it likes, and each frame is decoded the moment its last bit arrives.

The first frame under a slave-select assertion is a command:

- Bit 15 gives the access type: 1 is a write and 0 is a read.
- The low bits give the register address. The low byte is taken, then reduced modulo the bank size.

After a write command, every further frame in the same assertion is data. Each data frame is stored at the current address, and the address then steps up by one. A read command loads the addressed register into the MISO shifter as soon as the command frame completes, so the value comes out during the very next frame with no extra frame of delay.

The serial inputs are brought into the system clock domain through two-flop synchronisers, and all sampling and shifting happens on the system clock. A registered local read port lets the surrounding logic inspect any register.

Top module: `spi_regbank_slave`

## Requirements
- R1: Frames are 16 bits. MOSI is taken on each rising SCK edge, with the first bit received becoming bit 15. MISO presents bit 15 of the outgoing word first and advances one bit on each falling SCK edge inside a frame.
- R2: While slave select stays low, consecutive 16-bit frames are each decoded independently, back to back.
- R3: A command frame with bit 15 = 1 is a write. Each following frame in the same slave-select assertion is stored at the addressed register.
- R4: A command frame with bit 15 = 0 is a read and does not change any register.
- R5: The register address is command bits [5:0] (the low byte taken modulo 64). Bits [14:6] of a command are ignored.
- R6: After a read command, the addressed register's value is shifted out on MISO during the immediately following frame, MSB first.
- R7: After reset every one of the 64 registers holds 0xBEEF and MISO is low.
- R8: In a write burst the address increments after each data frame and wraps from 63 to 0.
- R9: A frame that does not follow a read command shifts out 0x0000 on MISO, and MISO is low while slave select is high.
- R10: Raising slave select discards any partial frame and any write burst. The next frame after slave select falls again is treated as a command.
- R11: The local read port returns the register selected by `lcl_addr` one system clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the master, idle low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_ss_n | input | 1 | Slave select, active low |
| spi_miso | output | 1 | Serial data to the master (registered) |
| lcl_addr | input | 6 | Local read port address |
| lcl_data | output | 16 | Local read port data (registered) |

## Verification
The assertions assume the following about the master:

- Each SCK phase lasts at least six system clocks, so the synchronised rising and falling edges are seen one at a time.
- MOSI is stable around every rising edge.
- Slave select changes only while SCK is low.

Under these conditions, the controller's reload of the MISO shifter always lands before the next frame's first falling edge, and a completed frame can only be reported while slave select is seen low.

The bench holds each SCK phase for eight system clocks, changes MOSI and slave select only with SCK low, and samples MISO just before raising SCK, as a mode-0 master does.

// File: rtl/spi_rb_pkg.sv
package spi_rb_pkg;
  localparam int FRAME_W = 16;
  localparam int CNT_W   = $clog2(FRAME_W);

  typedef logic [FRAME_W-1:0] frame_t;
endpackage

// File: rtl/spi_rb_sync.sv
module spi_rb_sync #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst)
          stg[g] <= RST_VAL;
        else if (g == 0)
          stg[g] <= d;
        else
          stg[g] <= stg[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_rb_shift.sv
module spi_rb_shift
  import spi_rb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sck_s,
  input  logic             mosi_s,
  input  logic             ss_s,
  input  logic             load_vld,
  input  frame_t           load_word,
  output logic             frame_done,
  output frame_t           frame_word,
  output logic             miso,
  output logic [CNT_W-1:0] bit_cnt
);
  logic   sck_q;
  logic   sck_rise;
  logic   sck_fall;
  frame_t rx_sr;
  frame_t tx_sr;

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q      <= 1'b0;
      rx_sr      <= '0;
      tx_sr      <= '0;
      bit_cnt    <= '0;
      frame_done <= 1'b0;
      frame_word <= '0;
      miso       <= 1'b0;
    end else begin
      sck_q      <= sck_s;
      frame_done <= 1'b0;
      miso       <= tx_sr[FRAME_W-1];
      if (ss_s) begin
        bit_cnt <= '0;
        rx_sr   <= '0;
        tx_sr   <= '0;
      end else begin
        if (sck_rise) begin
          rx_sr <= {rx_sr[FRAME_W-2:0], mosi_s};
          if (bit_cnt == CNT_W'(FRAME_W-1)) begin
            bit_cnt    <= '0;
            frame_done <= 1'b1;
            frame_word <= {rx_sr[FRAME_W-2:0], mosi_s};
          end else begin
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        if (load_vld)
          tx_sr <= load_word;
        else if (sck_fall && bit_cnt != '0)
          tx_sr <= {tx_sr[FRAME_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_rb_ctrl.sv
module spi_rb_ctrl
  import spi_rb_pkg::*;
#(
  parameter int     REGS      = 64,
  parameter frame_t RESET_VAL = 16'hBEEF,
  localparam int    ADDR_W    = $clog2(REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ss_s,
  input  logic              frame_done,
  input  frame_t            frame_word,
  input  logic [ADDR_W-1:0] lcl_addr,
  output frame_t            lcl_data,
  output logic              load_vld,
  output frame_t            load_word,
  output logic              wr_mode,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              bank_we
);
  frame_t            bank [REGS];
  logic [ADDR_W-1:0] cmd_addr;

  assign cmd_addr = frame_word[ADDR_W-1:0];
  assign bank_we  = frame_done & wr_mode & ~ss_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_mode   <= 1'b0;
      wr_addr   <= '0;
      load_vld  <= 1'b0;
      load_word <= '0;
    end else begin
      load_vld <= frame_done & ~ss_s;
      if (ss_s) begin
        wr_mode <= 1'b0;
      end else if (frame_done) begin
        load_word <= '0;
        if (wr_mode) begin
          wr_addr <= wr_addr + 1'b1;
        end else if (frame_word[FRAME_W-1]) begin
          wr_mode <= 1'b1;
          wr_addr <= cmd_addr;
        end else begin
          load_word <= bank[cmd_addr];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < REGS; i++) bank[i] <= RESET_VAL;
    end else if (bank_we) begin
      bank[wr_addr] <= frame_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lcl_data <= RESET_VAL;
    else     lcl_data <= bank[lcl_addr];
  end
endmodule

// File: rtl/spi_regbank_slave.sv
module spi_regbank_slave
  import spi_rb_pkg::*;
#(
  parameter int     REGS        = 64,
  parameter int     SYNC_STAGES = 2,
  parameter frame_t RESET_VAL   = 16'hBEEF,
  localparam int    ADDR_W      = $clog2(REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  input  logic              spi_ss_n,
  output logic              spi_miso,
  input  logic [ADDR_W-1:0] lcl_addr,
  output logic [15:0]       lcl_data
);
  logic [2:0]        pins_s;
  logic              sck_s;
  logic              mosi_s;
  logic              ss_sync;
  logic              frame_done;
  frame_t            frame_word;
  logic [CNT_W-1:0]  bit_cnt;
  logic              load_vld;
  frame_t            load_word;
  logic              wr_mode;
  logic [ADDR_W-1:0] wr_addr;
  logic              bank_we;

  spi_rb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) sync_i (
    .clk (clk),
    .rst (rst),
    .d   ({spi_ss_n, spi_mosi, spi_sck}),
    .q   (pins_s)
  );

  assign sck_s   = pins_s[0];
  assign mosi_s  = pins_s[1];
  assign ss_sync = pins_s[2];

  spi_rb_shift shift_i (
    .clk        (clk),
    .rst        (rst),
    .sck_s      (sck_s),
    .mosi_s     (mosi_s),
    .ss_s       (ss_sync),
    .load_vld   (load_vld),
    .load_word  (load_word),
    .frame_done (frame_done),
    .frame_word (frame_word),
    .miso       (spi_miso),
    .bit_cnt    (bit_cnt)
  );

  spi_rb_ctrl #(.REGS(REGS), .RESET_VAL(RESET_VAL)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .ss_s       (ss_sync),
    .frame_done (frame_done),
    .frame_word (frame_word),
    .lcl_addr   (lcl_addr),
    .lcl_data   (lcl_data),
    .load_vld   (load_vld),
    .load_word  (load_word),
    .wr_mode    (wr_mode),
    .wr_addr    (wr_addr),
    .bank_we    (bank_we)
  );
endmodule

// File: rtl/spi_regbank_chk.sv
module spi_regbank_chk #(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              ss_sync,
  input logic              spi_miso,
  input logic              frame_done,
  input logic [CNT_W-1:0]  bit_cnt,
  input logic              load_vld,
  input logic              wr_mode,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              bank_we
);
  // R9
  miso_idle_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ss_sync) && $past(ss_sync, 2)) |-> !spi_miso);

  // R2
  frame_in_select_chk: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> !$past(ss_sync));

  // R10
  abort_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ss_sync) |=> (bit_cnt == '0 && !wr_mode));

  // R6
  reload_after_frame_chk: assert property (@(posedge clk) disable iff (rst)
    load_vld |-> $past(frame_done));

  // R3
  write_mode_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_mode) |-> $past(frame_done));

  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    bank_we |=> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1)));
endmodule

bind spi_regbank_slave spi_regbank_chk #(.ADDR_W(ADDR_W), .CNT_W(spi_rb_pkg::CNT_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .ss_sync    (ss_sync),
  .spi_miso   (spi_miso),
  .frame_done (frame_done),
  .bit_cnt    (bit_cnt),
  .load_vld   (load_vld),
  .wr_mode    (wr_mode),
  .wr_addr    (wr_addr),
  .bank_we    (bank_we)
);

// File: tb/spi_regbank_slave_tb.sv
`timescale 1ns/1ps
module spi_regbank_slave_tb_top;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sck = 1'b0;
  logic        mosi = 1'b0;
  logic        ss_n = 1'b1;
  logic        miso;
  logic [5:0]  lcl_addr = '0;
  logic [15:0] lcl_data;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #2.5 clk = ~clk;

  spi_regbank_slave dut_i (
    .clk      (clk),
    .rst      (rst),
    .spi_sck  (sck),
    .spi_mosi (mosi),
    .spi_ss_n (ss_n),
    .spi_miso (miso),
    .lcl_addr (lcl_addr),
    .lcl_data (lcl_data)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sel_low();
    @(negedge clk); ss_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic sel_high();
    repeat (HALF) @(negedge clk);
    ss_n = 1'b1;
    repeat (4*HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic [15:0] tx, input int nbits, output logic [15:0] rx);
    rx = '0;
    for (int i = 15; i > 15 - nbits; i--) begin
      mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = miso;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic lcl_rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); lcl_addr = a;
    @(negedge clk);
    @(negedge clk); d = lcl_data;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    check("R7 miso low after reset", {15'd0, miso}, 16'h0000);
    lcl_rd(6'd0, d);  check("R7 R11 reg0 reset value", d, 16'hBEEF);
    lcl_rd(6'd63, d); check("R7 R11 reg63 reset value", d, 16'hBEEF);
  endtask

  task automatic t_write();
    logic [15:0] r0, r1, d;
    sel_low();
    xfer(16'h8005, 16, r0);
    xfer(16'h8009, 16, r1);
    sel_high();
    check("R9 miso zero on write command", r0, 16'h0000);
    check("R9 miso zero on data frame", r1, 16'h0000);
    lcl_rd(6'd5, d); check("R3 write stored", d, 16'h8009);
    lcl_rd(6'd6, d); check("R3 neighbour untouched", d, 16'hBEEF);
  endtask

  task automatic t_read();
    logic [15:0] r0, r1, r2, d;
    sel_low();
    xfer(16'h0005, 16, r0);
    xfer(16'h0007, 16, r1);
    xfer(16'h0000, 16, r2);
    sel_high();
    check("R9 no response on first frame", r0, 16'h0000);
    check("R6 R1 zero-lag read reg5", r1, 16'h8009);
    check("R6 R2 back-to-back read reg7", r2, 16'hBEEF);
    lcl_rd(6'd5, d); check("R4 read leaves register", d, 16'h8009);
  endtask

  task automatic t_burst();
    logic [15:0] r, d;
    sel_low();
    xfer(16'h803E, 16, r);
    xfer(16'h1111, 16, r);
    xfer(16'h2222, 16, r);
    xfer(16'h3333, 16, r);
    sel_high();
    lcl_rd(6'd62, d); check("R8 burst reg62", d, 16'h1111);
    lcl_rd(6'd63, d); check("R8 burst reg63", d, 16'h2222);
    lcl_rd(6'd0, d);  check("R8 burst wraps to reg0", d, 16'h3333);
    lcl_rd(6'd1, d);  check("R8 burst stops", d, 16'hBEEF);
  endtask

  task automatic t_addr();
    logic [15:0] r, d;
    sel_low();
    xfer(16'h80C1, 16, r);
    xfer(16'hA5A5, 16, r);
    sel_high();
    lcl_rd(6'd1, d); check("R5 low byte modulo 64 on write", d, 16'hA5A5);
    sel_low();
    xfer(16'h7F41, 16, r);
    xfer(16'h0000, 16, r);
    sel_high();
    check("R5 upper command bits ignored on read", r, 16'hA5A5);
  endtask

  task automatic t_abort();
    logic [15:0] r, d;
    sel_low();
    xfer(16'h8003, 7, r);
    sel_high();
    sel_low();
    xfer(16'h0003, 16, r);
    xfer(16'h0000, 16, r);
    sel_high();
    check("R10 partial frame discarded", r, 16'hBEEF);
    sel_low();
    xfer(16'h8004, 16, r);
    sel_high();
    sel_low();
    xfer(16'h0004, 16, r);
    xfer(16'h0000, 16, r);
    sel_high();
    check("R10 new select starts with command", r, 16'hBEEF);
    lcl_rd(6'd4, d); check("R10 burst ended by select", d, 16'hBEEF);
    check("R9 miso low while deselected", {15'd0, miso}, 16'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_burst();
    t_addr();
    t_abort();
    ended = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule